// File: doc/BRIEF.md
# Sign-Separated Huffman Weight Unpacker

This block rebuilds 4-bit sign-magnitude weight codes from three compressed streams and writes them, one per cycle at most, into a weight memory before a compute phase begins. The sign of every weight comes from its own bit stream. A second stream carries one flag per weight that marks zero weights. Only a non-zero weight draws a codeword from the third stream, which holds canonical Huffman codes. A decoded codeword gives a rank. A rank table turns the rank into a symbol, and a magnitude table turns the symbol into the 3-bit power-of-two exponent that all weights sharing that symbol use.

Software first fills the three small tables through a write port: codes per length, rank-to-symbol and symbol-to-magnitude. It then pulses `start` with the number of weights to unpack. Each stream delivers 32-bit words with a valid/ready handshake. The block raises `done` when the last weight has been written, or `err` when a codeword cannot be resolved.

Top module: `swd_weight_decoder`

## Requirements
- R1: After reset, `wr_en`, `done` and `err` are low, and all three stream ready outputs are low.
- R2: A stream's ready output is high only while a run is active and that stream's 32-bit buffer is empty. Each accepted word supplies 32 bits, used least significant bit first, and at most one bit per stream is used per cycle. Huffman codeword bits arrive most significant bit first.
- R3: When a weight's zero flag is 1, the weight is written as code {sign, 3'b000}, and the Huffman stream is not advanced for that weight.
- R4: Non-zero weights are decoded as canonical Huffman codes of length 1 to 8. The table entry for length L holds count_L. The first code of length 1 is 0, and the first code of length L+1 is (first_L + count_L) * 2. A length-L code whose offset from first_L lies in [0, count_L) selects rank = (sum of the counts of shorter lengths) + offset.
- R5: The written code has bit 3 equal to the weight's sign bit (1 = negative), and bits 2:0 equal to the magnitude table entry of the symbol that the rank table gives for the decoded rank.
- R6: The write address is 0 for the first weight of a run and increases by one for each weight written.
- R7: `done` rises in the same cycle as the write of the last of `weight_count` weights, or one cycle after `start` when `weight_count` is 0. No further write occurs until the next `start`.
- R8: A codeword with no match by length 8, or one that resolves to a rank of 8 or more, sets `err`. The flag stays set and nothing more is written until the next `start`, which clears it.
- R9: Table writes are ignored while a run is active. Table write kinds: 0 sets count for length idx+1; 1 sets the symbol for rank idx; 2 sets the magnitude for symbol idx.
- R10: `start` discards any bits left in the three buffers from the previous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a run; accepted only while idle |
| weight_count | input | 11 | Number of weights in the run, sampled at start |
| cfg_we | input | 1 | Table write strobe |
| cfg_kind | input | 2 | Table selector: 0 counts, 1 rank-to-symbol, 2 magnitudes |
| cfg_idx | input | 3 | Table entry index |
| cfg_data | input | 4 | Table entry value |
| sgn_valid | input | 1 | Sign word valid |
| sgn_data | input | 32 | Sign word |
| sgn_ready | output | 1 | Sign buffer can take a word |
| zf_valid | input | 1 | Zero-flag word valid |
| zf_data | input | 32 | Zero-flag word |
| zf_ready | output | 1 | Zero-flag buffer can take a word |
| hf_valid | input | 1 | Huffman word valid |
| hf_data | input | 32 | Huffman word |
| hf_ready | output | 1 | Huffman buffer can take a word |
| wr_en | output | 1 | Weight memory write strobe |
| wr_addr | output | 10 | Weight memory address |
| wr_code | output | 4 | Sign-magnitude weight code |
| done | output | 1 | All weights of the run written |
| err | output | 1 | Sticky invalid-codeword flag |

## Verification
Two functions can land in the same cycle. One pair is a table write on the configuration port and a weight write, which reads that same table. The other is the final weight write and the rise of `done`. The first case is provoked by driving a magnitude-table write a few cycles into a long run. It is judged by whether every later weight still carries the magnitude that was loaded before `start`. The second is judged by checking that `done` and the last write appear together, and that no write follows. Randomized tables, symbol permutations and zero densities spread codeword boundaries across word boundaries, so that a bit request and a word refill meet at every alignment.

// File: rtl/swd_pkg.sv
// Shared types for the sign-separated weight unpacker.
package swd_pkg;
    // Selector for the configuration write port.
    typedef enum logic [1:0] {
        CFG_LENCOUNT  = 2'd0,
        CFG_RANKSYM   = 2'd1,
        CFG_MAGNITUDE = 2'd2
    } cfg_kind_e;

    // Decode sequencer state.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_HUFF = 2'd2
    } dec_state_e;
endpackage

// File: rtl/swd_bitbuf.sv
// One-word bit buffer. Takes a word only while run is high and it is empty.
// Hands out bits LSB first, one per take pulse. flush drops leftover bits.
// Assumes take is raised only when bit_avail is high.
module swd_bitbuf #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    input  logic              take,
    output logic              bit_avail,
    output logic              bit_val
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] word_q;
    logic [CNT_W-1:0]  left_q;

    assign in_ready  = run && (left_q == '0);
    assign bit_avail = (left_q != '0);
    assign bit_val   = word_q[0];

    // Load, flush or shift the held word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            left_q <= '0;
        end else if (in_valid && in_ready) begin
            word_q <= in_data;
            left_q <= CNT_W'(WORD_W);
        end else if (flush) begin
            left_q <= '0;
        end else if (take) begin
            word_q <= word_q >> 1;
            left_q <= left_q - 1'b1;
        end
    end

    AST_TAKE_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> bit_avail); // R2
    AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (bit_avail && !in_ready)); // R2
endmodule

// File: rtl/swd_code_table.sv
// Holds the three decode tables: codes per length, rank-to-symbol and
// symbol-to-magnitude. Writes are dropped while lock is high. Reads are
// combinational. The magnitude lookup is chained behind the symbol lookup.
module swd_code_table
    import swd_pkg::*;
#(
    parameter int MAX_LEN = 8,
    parameter int NUM_SYM = 8,
    parameter int MAG_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_kind,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic [LSEL_W-1:0] len_sel,
    output logic [CNT_W-1:0]  len_count,
    input  logic [RANK_W-1:0] rank_sel,
    output logic [MAG_W-1:0]  mag_out
);
    localparam int CNT_W  = $clog2(NUM_SYM + 1);
    localparam int RANK_W = $clog2(NUM_SYM);
    localparam int LSEL_W = $clog2(MAX_LEN);
    localparam int IDX_W  = $clog2((MAX_LEN > NUM_SYM) ? MAX_LEN : NUM_SYM);
    localparam int CFG_W  = (CNT_W > MAG_W) ? CNT_W : MAG_W;

    logic [CNT_W-1:0]  cnt_tab [MAX_LEN];
    logic [RANK_W-1:0] sym_tab [NUM_SYM];
    logic [MAG_W-1:0]  mag_tab [NUM_SYM];
    logic [RANK_W-1:0] sym_sel;
    logic              wr_ok;

    assign wr_ok = cfg_we && !lock;

    // Update the per-length code counts.
    always_ff @(posedge clk) begin
        for (int i = 0; i < MAX_LEN; i++) begin
            if (!rst_n) cnt_tab[i] <= '0;
            else if (wr_ok && cfg_kind == CFG_LENCOUNT && cfg_idx == IDX_W'(i))
                cnt_tab[i] <= cfg_data[CNT_W-1:0];
        end
    end

    // Update the rank-to-symbol and symbol-to-magnitude entries.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_SYM; i++) begin
            if (!rst_n) begin
                sym_tab[i] <= '0;
                mag_tab[i] <= '0;
            end else if (wr_ok && cfg_idx == IDX_W'(i)) begin
                if (cfg_kind == CFG_RANKSYM)   sym_tab[i] <= cfg_data[RANK_W-1:0];
                if (cfg_kind == CFG_MAGNITUDE) mag_tab[i] <= cfg_data[MAG_W-1:0];
            end
        end
    end

    // Combinational reads.
    always_comb begin
        len_count = cnt_tab[len_sel];
        sym_sel   = sym_tab[rank_sel];
        mag_out   = mag_tab[sym_sel];
    end
endmodule

// File: rtl/swd_canon_step.sv
// One step of canonical Huffman matching. It appends one bit to the partial
// code and tests the result against the code range of the current length.
// It also gives the first code and the rank base for the next length.
// Assumes first and base were kept by the caller, starting at zero.
module swd_canon_step #(
    parameter int ACC_W   = 14,
    parameter int CNT_W   = 4,
    parameter int RANK_W  = 3,
    parameter int NUM_SYM = 8
) (
    input  logic [ACC_W-1:0]  code_prev,
    input  logic              bit_in,
    input  logic [ACC_W-1:0]  first,
    input  logic [ACC_W-1:0]  base,
    input  logic [CNT_W-1:0]  count,
    output logic              hit,
    output logic              overflow,
    output logic [RANK_W-1:0] rank,
    output logic [ACC_W-1:0]  code_next,
    output logic [ACC_W-1:0]  first_next,
    output logic [ACC_W-1:0]  base_next
);
    logic [ACC_W-1:0] diff;
    logic [ACC_W-1:0] rank_full;
    logic             in_range;

    // Range test and rank arithmetic for the current length.
    always_comb begin
        code_next  = (code_prev << 1) | ACC_W'(bit_in);
        diff       = code_next - first;
        in_range   = (code_next >= first) && (diff < ACC_W'(count));
        rank_full  = base + diff;
        hit        = in_range && (rank_full < ACC_W'(NUM_SYM));
        overflow   = in_range && !hit;
        rank       = rank_full[RANK_W-1:0];
        first_next = (first + ACC_W'(count)) << 1;
        base_next  = base + ACC_W'(count);
    end
endmodule

// File: rtl/swd_weight_decoder.sv
// Top of the weight unpacker. For each weight it takes a sign bit and a zero
// flag together. Zero weights are written at once. Non-zero weights then draw
// Huffman bits until a canonical match, and their magnitude is looked up
// through the rank and symbol tables. Writes go out through a register stage.
// Assumes tables are loaded before start. Stream index 0 = sign, 1 = zero
// flag, 2 = Huffman.
module swd_weight_decoder
    import swd_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int MAX_LEN = 8,
    parameter int NUM_SYM = 8,
    parameter int MAG_W   = 3,
    parameter int ADDR_W  = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [ADDR_W:0]       weight_count,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_kind,
    input  logic [IDX_W-1:0]      cfg_idx,
    input  logic [CFG_W-1:0]      cfg_data,
    input  logic                  sgn_valid,
    input  logic [WORD_W-1:0]     sgn_data,
    output logic                  sgn_ready,
    input  logic                  zf_valid,
    input  logic [WORD_W-1:0]     zf_data,
    output logic                  zf_ready,
    input  logic                  hf_valid,
    input  logic [WORD_W-1:0]     hf_data,
    output logic                  hf_ready,
    output logic                  wr_en,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [MAG_W:0]        wr_code,
    output logic                  done,
    output logic                  err
);
    localparam int CNT_W  = $clog2(NUM_SYM + 1);
    localparam int RANK_W = $clog2(NUM_SYM);
    localparam int LSEL_W = $clog2(MAX_LEN);
    localparam int IDX_W  = $clog2((MAX_LEN > NUM_SYM) ? MAX_LEN : NUM_SYM);
    localparam int CFG_W  = (CNT_W > MAG_W) ? CNT_W : MAG_W;
    localparam int ACC_W  = MAX_LEN + CNT_W + 2;
    localparam int NSTR   = 3;
    localparam int S_SGN  = 0;
    localparam int S_ZF   = 1;
    localparam int S_HF   = 2;

    dec_state_e          state_q;
    logic [ACC_W-1:0]    code_q, first_q, base_q;
    logic [LSEL_W-1:0]   len_q;
    logic                sign_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [ADDR_W:0]     left_q;
    logic                done_q, err_q;
    logic                wr_en_q;
    logic [ADDR_W-1:0]   wr_addr_q;
    logic [MAG_W:0]      wr_code_q;

    logic [NSTR-1:0]             s_valid, s_ready, s_avail, s_bit, s_take;
    logic [NSTR-1:0][WORD_W-1:0] s_data;
    logic                        busy, flush;
    logic                        head_fire, huff_fire, emit, fail, last_len;
    logic [MAG_W:0]              emit_code;
    logic [CNT_W-1:0]            len_count;
    logic [MAG_W-1:0]            mag;
    logic                        hit, overflow;
    logic [RANK_W-1:0]           rank;
    logic [ACC_W-1:0]            code_nx, first_nx, base_nx;

    assign busy  = (state_q != ST_IDLE);
    assign flush = (state_q == ST_IDLE) && start;

    assign s_valid = {hf_valid, zf_valid, sgn_valid};
    assign s_data  = {hf_data, zf_data, sgn_data};
    assign sgn_ready = s_ready[S_SGN];
    assign zf_ready  = s_ready[S_ZF];
    assign hf_ready  = s_ready[S_HF];

    // One bit buffer per input stream.
    for (genvar g = 0; g < NSTR; g++) begin : g_buf
        swd_bitbuf #(.WORD_W(WORD_W)) u_buf (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (busy),
            .flush    (flush),
            .in_valid (s_valid[g]),
            .in_data  (s_data[g]),
            .in_ready (s_ready[g]),
            .take     (s_take[g]),
            .bit_avail(s_avail[g]),
            .bit_val  (s_bit[g])
        );
    end

    swd_code_table #(.MAX_LEN(MAX_LEN), .NUM_SYM(NUM_SYM), .MAG_W(MAG_W)) u_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock     (busy),
        .cfg_we   (cfg_we),
        .cfg_kind (cfg_kind),
        .cfg_idx  (cfg_idx),
        .cfg_data (cfg_data),
        .len_sel  (len_q),
        .len_count(len_count),
        .rank_sel (rank),
        .mag_out  (mag)
    );

    swd_canon_step #(.ACC_W(ACC_W), .CNT_W(CNT_W), .RANK_W(RANK_W),
                     .NUM_SYM(NUM_SYM)) u_step (
        .code_prev (code_q),
        .bit_in    (s_bit[S_HF]),
        .first     (first_q),
        .base      (base_q),
        .count     (len_count),
        .hit       (hit),
        .overflow  (overflow),
        .rank      (rank),
        .code_next (code_nx),
        .first_next(first_nx),
        .base_next (base_nx)
    );

    // Bit consumption, write decision and error decision for this cycle.
    always_comb begin
        head_fire = (state_q == ST_HEAD) && s_avail[S_SGN] && s_avail[S_ZF];
        huff_fire = (state_q == ST_HUFF) && s_avail[S_HF];
        s_take    = {huff_fire, head_fire, head_fire};
        last_len  = (len_q == LSEL_W'(MAX_LEN - 1));
        emit      = (head_fire && s_bit[S_ZF]) || (huff_fire && hit);
        fail      = huff_fire && !hit && (overflow || last_len);
        emit_code = (state_q == ST_HEAD) ? {s_bit[S_SGN], MAG_W'(0)}
                                         : {sign_q, mag};
    end

    // Sequencer: run control, canonical search state and write bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= '0;
            first_q <= '0;
            base_q  <= '0;
            len_q   <= '0;
            sign_q  <= 1'b0;
            addr_q  <= '0;
            left_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        err_q  <= 1'b0;
                        addr_q <= '0;
                        left_q <= weight_count;
                        done_q <= (weight_count == '0);
                        state_q <= (weight_count == '0) ? ST_IDLE : ST_HEAD;
                    end
                end
                ST_HEAD: begin
                    if (head_fire && !s_bit[S_ZF]) begin
                        sign_q  <= s_bit[S_SGN];
                        code_q  <= '0;
                        first_q <= '0;
                        base_q  <= '0;
                        len_q   <= '0;
                        state_q <= ST_HUFF;
                    end
                end
                ST_HUFF: begin
                    if (fail) begin
                        err_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (huff_fire && !hit) begin
                        code_q  <= code_nx;
                        first_q <= first_nx;
                        base_q  <= base_nx;
                        len_q   <= len_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
            if (emit) begin
                addr_q <= addr_q + 1'b1;
                left_q <= left_q - 1'b1;
                if (left_q == (ADDR_W+1)'(1)) begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end else begin
                    state_q <= ST_HEAD;
                end
            end
        end
    end

    // Registered write port toward the weight memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_q   <= 1'b0;
            wr_addr_q <= '0;
            wr_code_q <= '0;
        end else begin
            wr_en_q <= emit;
            if (emit) begin
                wr_addr_q <= addr_q;
                wr_code_q <= emit_code;
            end
        end
    end

    assign wr_en   = wr_en_q;
    assign wr_addr = wr_addr_q;
    assign wr_code = wr_code_q;
    assign done    = done_q;
    assign err     = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !start) |=> err_q); // R8
    AST_NO_WRITE_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> !wr_en_q); // R8
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_q |=> (!wr_en_q || wr_addr_q == ADDR_W'($past(wr_addr_q) + 1'b1))); // R6
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !start) |=> !wr_en_q); // R7
endmodule

// File: tb/tb_swd_weight_decoder.sv
`timescale 1ns/1ps
module tb_swd_weight_decoder;
    localparam int WORD_W  = 32;
    localparam int MAX_LEN = 8;
    localparam int NUM_SYM = 8;
    localparam int ADDR_W  = 10;
    localparam int LIMIT   = 6000;

    typedef logic [31:0] wq_t[$];
    typedef bit bq_t[$];

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [ADDR_W:0] weight_count = '0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_kind = '0;
    logic [2:0] cfg_idx = '0;
    logic [3:0] cfg_data = '0;
    logic [2:0] in_v = '0;
    logic [31:0] in_d [3];
    logic [2:0] in_r;
    logic wr_en, done, err;
    logic [ADDR_W-1:0] wr_addr;
    logic [3:0] wr_code;

    swd_weight_decoder #(.WORD_W(WORD_W), .MAX_LEN(MAX_LEN), .NUM_SYM(NUM_SYM),
                         .MAG_W(3), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .weight_count(weight_count),
        .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .sgn_valid(in_v[0]), .sgn_data(in_d[0]), .sgn_ready(in_r[0]),
        .zf_valid(in_v[1]), .zf_data(in_d[1]), .zf_ready(in_r[1]),
        .hf_valid(in_v[2]), .hf_data(in_d[2]), .hf_ready(in_r[2]),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_code(wr_code), .done(done), .err(err));

    always #4 clk = ~clk;

    int n_checks = 0, n_fail = 0;
    int cnts [MAX_LEN];
    int perm [NUM_SYM];
    int rank_of [NUM_SYM];
    int mag [NUM_SYM];
    bq_t sb, zb, hb;
    logic [3:0] expq[$];
    logic [31:0] wds [3][$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Canonical code of a rank, built from the counts per length.
    function automatic void code_of(input int rank, output int code, output int len);
        int first = 0, base = 0;
        code = 0; len = 0;
        for (int l = 0; l < MAX_LEN; l++) begin
            if (len == 0 && rank < base + cnts[l]) begin
                code = first + (rank - base);
                len = l + 1;
            end
            base += cnts[l];
            first = (first + cnts[l]) << 1;
        end
    endfunction

    function automatic wq_t pack(input bq_t b);
        wq_t w;
        logic [31:0] cur = $urandom;
        int nb = 0;
        foreach (b[i]) begin
            cur[nb] = b[i];
            nb++;
            if (nb == 32) begin w.push_back(cur); cur = $urandom; nb = 0; end
        end
        if (nb != 0) w.push_back(cur);
        return w;
    endfunction

    task automatic clear_streams();
        sb.delete(); zb.delete(); hb.delete(); expq.delete();
    endtask

    task automatic push_code(input int code, input int len);
        for (int i = len - 1; i >= 0; i--) hb.push_back(bit'((code >> i) & 1));
    endtask

    task automatic add_weight(input bit s, input bit z, input int sym, input bit rec);
        int c, l;
        sb.push_back(s); zb.push_back(z);
        if (!z) begin
            code_of(rank_of[sym], c, l);
            push_code(c, l);
        end
        if (rec) expq.push_back({s, z ? 3'b000 : 3'(mag[sym])});
    endtask

    task automatic cfg_write(input int kind, input int idx, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = 2'(kind); cfg_idx = 3'(idx); cfg_data = 4'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_table(input int c0, input int c1, input int c2, input int c3,
                             input int c4, input int c5, input int c6, input int c7);
        cnts = '{c0, c1, c2, c3, c4, c5, c6, c7};
        for (int i = 0; i < NUM_SYM; i++) perm[i] = i;
        for (int i = NUM_SYM - 1; i > 0; i--) begin
            int j = int'($urandom % (i + 1));
            int t = perm[i]; perm[i] = perm[j]; perm[j] = t;
        end
        for (int i = 0; i < NUM_SYM; i++) begin
            rank_of[perm[i]] = i;
            mag[i] = int'($urandom % 8);
        end
        for (int i = 0; i < MAX_LEN; i++) cfg_write(0, i, cnts[i]);
        for (int i = 0; i < NUM_SYM; i++) cfg_write(1, i, perm[i]);
        for (int i = 0; i < NUM_SYM; i++) cfg_write(2, i, mag[i]);
    endtask

    task automatic run(input int n, input bit err_exp, input int poke_at, input string tag);
        int k = 0, cyc = 0;
        int wi [3];
        bit rp [3];
        wds[0] = pack(sb); wds[1] = pack(zb); wds[2] = pack(hb);
        for (int s = 0; s < 3; s++) begin wi[s] = 0; rp[s] = 1'b0; end
        @(negedge clk);
        in_v = '0;
        weight_count = (ADDR_W+1)'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (1) begin
            for (int s = 0; s < 3; s++) begin
                if (in_v[s] && rp[s]) in_v[s] = 1'b0;
                if (!in_v[s] && wi[s] < wds[s].size()) begin
                    in_d[s] = wds[s][wi[s]]; wi[s]++; in_v[s] = 1'b1;
                end
                rp[s] = in_r[s];
            end
            if (cyc == poke_at) begin
                cfg_we = 1'b1; cfg_kind = 2'd2; cfg_idx = 3'(perm[0]);
                cfg_data = 4'(~mag[perm[0]] & 7);
            end else cfg_we = 1'b0;
            if (wr_en) begin
                if (k < expq.size())
                    chk(wr_code == expq[k], {"R3 R5 code ", tag}, wr_code, expq[k]);
                else chk(1'b0, {"R7 R8 extra write ", tag}, k, expq.size());
                chk(wr_addr == ADDR_W'(k), {"R6 address ", tag}, wr_addr, k);
                k++;
            end
            if (done || err) break;
            if (cyc > LIMIT) begin chk(1'b0, {"R7 run timeout ", tag}, cyc, LIMIT); break; end
            @(negedge clk);
            cyc++;
        end
        cfg_we = 1'b0;
        in_v = '0;
        chk(k == expq.size(), {"R4 R7 write count ", tag}, k, expq.size());
        chk(err == err_exp, {"R8 err flag ", tag}, err, err_exp);
        chk(done == !err_exp, {"R7 done flag ", tag}, done, !err_exp);
        if (err_exp) begin
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (wr_en || !err) begin
                    chk(1'b0, {"R8 quiet after error ", tag}, wr_en, 0);
                    break;
                end
            end
            chk(err == 1'b1, {"R8 err held ", tag}, err, 1);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        in_d[0] = '0; in_d[1] = '0; in_d[2] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(wr_en == 1'b0 && done == 1'b0 && err == 1'b0, "R1 outputs after reset",
            {wr_en, done, err}, 0);
        chk(in_r == 3'b000, "R1 R2 ready low while idle", in_r, 0);

        // R7 empty run
        set_table(1, 1, 1, 1, 1, 1, 2, 0);
        clear_streams();
        run(0, 1'b0, -1, "R7 zero count");

        // R3 all zero weights, no Huffman words at all
        clear_streams();
        for (int i = 0; i < 40; i++) add_weight(bit'($urandom % 2), 1'b1, 0, 1'b1);
        run(40, 1'b0, -1, "R3 all zero R10");

        // R4 longest codes only, crossing word boundaries
        clear_streams();
        for (int i = 0; i < 70; i++) add_weight(bit'($urandom % 2), 1'b0, perm[7], 1'b1);
        run(70, 1'b0, -1, "R4 long codes R2");

        // R9 table write during a run is dropped
        clear_streams();
        for (int i = 0; i < 60; i++) add_weight(bit'($urandom % 2), 1'b0, perm[0], 1'b1);
        run(60, 1'b0, 4, "R9 poke");

        // Random tables and weights
        for (int r = 0; r < 24; r++) begin
            int n = 1 + int'($urandom % 80);
            if ($urandom % 2) set_table(1, 1, 1, 1, 1, 1, 2, 0);
            else set_table(0, 0, 8, 0, 0, 0, 0, 0);
            clear_streams();
            for (int i = 0; i < n; i++)
                add_weight(bit'($urandom % 2), ($urandom % 10) < 4, int'($urandom % 8), 1'b1);
            run(n, 1'b0, (r % 3 == 0) ? 2 : -1, "R4 R5 random R10");
        end

        // R8 no match by length 8
        set_table(0, 1, 1, 1, 1, 1, 1, 2);
        clear_streams();
        for (int i = 0; i < 5; i++)
            add_weight(bit'($urandom % 2), ($urandom % 2) == 1, int'($urandom % 8), 1'b1);
        sb.push_back(1'b1); zb.push_back(1'b0); push_code(255, 8);
        for (int i = 0; i < 3; i++) add_weight(1'b0, 1'b0, 1, 1'b0);
        run(9, 1'b1, -1, "R8 unmatched");

        // R8 rank beyond table
        set_table(0, 0, 7, 2, 0, 0, 0, 0);
        clear_streams();
        for (int i = 0; i < 4; i++) add_weight(1'b0, 1'b0, int'($urandom % 8), 1'b1);
        sb.push_back(1'b0); zb.push_back(1'b0); push_code(15, 4);
        add_weight(1'b1, 1'b0, 2, 1'b0);
        run(6, 1'b1, -1, "R8 rank overflow");

        // R8 recovery: start clears the flag
        set_table(1, 1, 1, 1, 1, 1, 2, 0);
        clear_streams();
        for (int i = 0; i < 20; i++)
            add_weight(bit'($urandom % 2), ($urandom % 10) < 3, int'($urandom % 8), 1'b1);
        run(20, 1'b0, -1, "R8 recovery R10");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule